// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block drives the entry into a handler for an 8-bit processor core. Between instructions the core raises `boundary`; when the sequencer is idle at such a boundary it decides between a reset request, a non-maskable request and a set of level-sensitive maskable request bits. It then runs a fixed bus sequence on a one-port byte memory and hands the core a new program counter, stack pointer and status byte through a single `load` strobe.

For an interrupt the sequencer saves the return program counter and the status byte on the stack page, fetches the handler address from a vector pair, and raises the interrupt-disable flag where the source calls for it. For a reset it fetches the start address, rebuilds the status byte and tells the core to leave its halted state. Instruction execution stays in the core. The sequencer latches the core's program counter, stack pointer and status when a sequence starts, so the core may change them afterwards.

Top module: `irq_entry_seq`

## Requirements
- R1: A maskable interrupt is pending while at least one bit of `irq_src` is 1, and it is taken at an idle boundary only when `iflag_prev` (the interrupt-disable flag, status bit 2, as it stood before the previous instruction) is 0. A boundary with the flag set, or with no bits set, produces no bus activity.
- R2: At a boundary with both a non-maskable and a maskable request pending, the non-maskable one is served, regardless of `iflag_prev`. Its pending state is cleared by that entry. The maskable bits are levels, and if they are still 1 they are served at a later boundary.
- R3: While `jammed` is 1, neither a non-maskable nor a maskable request starts a sequence. A non-maskable request that is pending at such a boundary is discarded.
- R4: An interrupt entry writes three bytes at address 0x0100 + SP, with SP falling by one after each write and wrapping within the page. The bytes are written in this order: PC[15:8], then PC[7:0], then the status with bit 4 cleared and bit 5 set. `sp_out` is SP minus 3.
- R5: The handler address is read low byte first, from 0xFFFA/0xFFFB for a non-maskable entry and from 0xFFFE/0xFFFF for a maskable one, and `pc_out` is {high, low}.
- R6: A maskable entry returns the latched status with bit 2 set. A non-maskable entry returns the latched status unchanged.
- R7: If a boundary is sampled on clock edge N, the writes of an interrupt entry appear in cycles N+1 to N+3, the vector reads in N+4 and N+5, and `load` in N+7. `busy` covers cycles N+1 to N+7.
- R8: A reset entry reads 0xFFFC then 0xFFFD in cycles N+1 and N+2 and makes no writes. It raises `load` together with `jam_clr` in cycle N+4, with `sp_out` equal to the latched SP and `status_out` equal to 0x04. It runs even while `jammed` is 1.
- R9: A pending reset request wins over both other requests. Reset and non-maskable requests that arrive during a sequence are held, and a boundary raised while `busy` is 1 is ignored. Held requests are served at the first idle boundary after the sequence.
- R10: While `rst_n` is low and afterwards until a sequence starts, `busy`, `mem_wr`, `mem_rd`, `load` and `jam_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| boundary | input | 1 | Core is between instructions |
| rst_req | input | 1 | Pulse requesting a processor reset entry |
| nmi_req | input | 1 | Pulse requesting a non-maskable entry |
| irq_src | input | NSRC | Level maskable request bits, one per source |
| jammed | input | 1 | Core is halted and takes no interrupts |
| iflag_prev | input | 1 | Interrupt-disable flag before the previous instruction |
| pc_in | input | 2*DW | Core program counter (return address) |
| sp_in | input | DW | Core stack pointer |
| status_in | input | DW | Core status byte |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 2*DW | Memory address |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | DW | Write data |
| busy | output | 1 | Sequence in progress |
| load | output | 1 | Core takes pc_out, sp_out, status_out this cycle |
| pc_out | output | 2*DW | Handler or start address |
| sp_out | output | DW | New stack pointer |
| status_out | output | DW | New status byte |
| jam_clr | output | 1 | Core leaves its halted state (reset only) |

## Verification
Each bus event and each load strobe has a fixed cycle relative to the boundary edge. Writes come 1 to 3 cycles after it and reads 4 and 5 cycles after it, and for an interrupt the load comes 7 cycles after it. For a reset the reads come 1 and 2 cycles after it and the load 4 cycles after it. The driver stamps each expected event with the absolute cycle it is due in. The monitor samples on the falling edge, tags every strobe it sees with the current cycle, and compares it with the head of the queue, so an event that comes early, comes late or is not expected counts as a failure. The checks for ignored or masked requests compare the count of observed bus events before and after the boundary.

// File: rtl/irq_seq_pkg.sv
// Shared types for the entry sequencer: request source and sequence state.
// Assumes an 8-bit style status byte with disable, break and unused bits.
package irq_seq_pkg;
    typedef enum logic [1:0] {SRC_NONE, SRC_RESET, SRC_NMI, SRC_IRQ} src_t;
    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P,
        ST_RD_LO, ST_RD_HI, ST_RD_WAIT, ST_DONE
    } seq_st_t;
    localparam int FLAG_I = 2;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;
endpackage

// File: rtl/irq_seq_arb.sv
// Priority pick among reset, non-maskable and maskable requests.
// Assumes the caller starts a sequence only at an idle boundary.
module irq_seq_arb
    import irq_seq_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic [NSRC-1:0] irq_src,
    input  logic            nmi_pend,
    input  logic            rst_pend,
    input  logic            jammed,
    input  logic            iflag_prev,
    output src_t            pick
);
    logic irq_live;
    assign irq_live = (|irq_src) && !iflag_prev;

    // Fixed priority: reset, then (unless halted) NMI, then unmasked IRQ.
    always_comb begin
        if (rst_pend)       pick = SRC_RESET;
        else if (jammed)    pick = SRC_NONE;
        else if (nmi_pend)  pick = SRC_NMI;
        else if (irq_live)  pick = SRC_IRQ;
        else                pick = SRC_NONE;
    end
endmodule

// File: rtl/irq_seq_pend.sv
// Holds edge-style reset and non-maskable requests until serviced.
// Assumes req pulses are single-cycle; a new pulse wins over a clear.
module irq_seq_pend
    import irq_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic nmi_req,
    input  logic start,
    input  src_t pick,
    input  logic drop_nmi,
    input  logic boundary,
    output logic rst_pend,
    output logic nmi_pend
);
    // Set on request, clear when the matching sequence starts or NMI is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pend <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            rst_pend <= rst_req | (rst_pend & !(start && pick == SRC_RESET));
            nmi_pend <= nmi_req | (nmi_pend & !((start && pick == SRC_NMI) || drop_nmi));
        end
    end

    AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pend && !boundary |=> nmi_pend); // R9
    AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend && !boundary |=> rst_pend); // R9
endmodule

// File: rtl/irq_seq_fsm.sv
// Bus sequencer: pushes return state, fetches the vector, builds outputs.
// Assumes a memory whose read data is valid one cycle after mem_rd.
module irq_seq_fsm
    import irq_seq_pkg::*;
#(
    parameter int              DW         = 8,
    parameter logic [DW-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DW-1:0] VEC_NMI    = 16'hFFFA,
    parameter logic [2*DW-1:0] VEC_RST    = 16'hFFFC,
    parameter logic [2*DW-1:0] VEC_IRQ    = 16'hFFFE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  src_t            kind_in,
    input  logic [2*DW-1:0] pc_in,
    input  logic [DW-1:0]   sp_in,
    input  logic [DW-1:0]   status_in,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] mem_addr,
    output logic            mem_wr,
    output logic            mem_rd,
    output logic [DW-1:0]   mem_wdata,
    output logic            busy,
    output logic            load,
    output logic [2*DW-1:0] pc_out,
    output logic [DW-1:0]   sp_out,
    output logic [DW-1:0]   status_out,
    output logic            jam_clr
);
    localparam int            AW     = 2 * DW;
    localparam logic [DW-1:0] ONE    = DW'(1);
    localparam logic [DW-1:0] MASK_I = ONE << FLAG_I;
    localparam logic [DW-1:0] MASK_B = ONE << FLAG_B;
    localparam logic [DW-1:0] MASK_U = ONE << FLAG_U;

    seq_st_t         state;
    src_t            kind_q;
    logic [AW-1:0]   pc_q;
    logic [DW-1:0]   sp_q, st_q, vec_lo, vec_hi;
    logic [AW-1:0]   vec_base;
    logic [3:0]      len_q;

    // State walk plus latching of core state and fetched vector bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind_q <= SRC_NONE;
            pc_q   <= '0;
            sp_q   <= '0;
            st_q   <= '0;
            vec_lo <= '0;
            vec_hi <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    kind_q <= kind_in;
                    pc_q   <= pc_in;
                    sp_q   <= sp_in;
                    st_q   <= status_in;
                    state  <= (kind_in == SRC_RESET) ? ST_RD_LO : ST_PUSH_H;
                end
                ST_PUSH_H:  begin sp_q <= sp_q - ONE; state <= ST_PUSH_L; end
                ST_PUSH_L:  begin sp_q <= sp_q - ONE; state <= ST_PUSH_P; end
                ST_PUSH_P:  begin sp_q <= sp_q - ONE; state <= ST_RD_LO;  end
                ST_RD_LO:   state <= ST_RD_HI;
                ST_RD_HI:   begin vec_lo <= mem_rdata; state <= ST_RD_WAIT; end
                ST_RD_WAIT: begin vec_hi <= mem_rdata; state <= ST_DONE;    end
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Vector pair chosen by the latched source.
    always_comb begin
        case (kind_q)
            SRC_RESET: vec_base = VEC_RST;
            SRC_NMI:   vec_base = VEC_NMI;
            default:   vec_base = VEC_IRQ;
        endcase
    end

    // Bus strobes, address and write data per state.
    always_comb begin
        mem_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_H: begin mem_wr = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[AW-1:DW]; end
            ST_PUSH_L: begin mem_wr = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = pc_q[DW-1:0]; end
            ST_PUSH_P: begin mem_wr = 1'b1; mem_addr = {STACK_PAGE, sp_q}; mem_wdata = (st_q & ~MASK_B) | MASK_U; end
            ST_RD_LO:  begin mem_rd = 1'b1; mem_addr = vec_base; end
            ST_RD_HI:  begin mem_rd = 1'b1; mem_addr = vec_base + AW'(1); end
            default: ;
        endcase
    end

    // Hand-over values for the core.
    always_comb begin
        busy    = (state != ST_IDLE);
        load    = (state == ST_DONE);
        jam_clr = load && (kind_q == SRC_RESET);
        pc_out  = {vec_hi, vec_lo};
        sp_out  = sp_q;
        case (kind_q)
            SRC_RESET: status_out = MASK_I;
            SRC_IRQ:   status_out = st_q | MASK_I;
            default:   status_out = st_q;
        endcase
    end

    // Checker counter: cycles spent busy before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n)               len_q <= '0;
        else if (state == ST_IDLE) len_q <= '0;
        else                       len_q <= len_q + 4'd1;
    end

    AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr[AW-1:DW] == STACK_PAGE); // R4
    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && $past(mem_wr) |-> mem_addr[DW-1:0] == $past(mem_addr[DW-1:0]) - ONE); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R7
    AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> len_q == ((kind_q == SRC_RESET) ? 4'd3 : 4'd6)); // R7
    AST_RST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && kind_q == SRC_RESET |-> !mem_wr); // R8
    AST_VEC_AREA: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr[AW-1:3] == {(AW-3){1'b1}}); // R5
endmodule

// File: rtl/irq_entry_seq.sv
// Top: arbitrates entry requests at idle boundaries and runs the sequence.
// Assumes boundary is only raised between instructions by the core.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary,
    input  logic            rst_req,
    input  logic            nmi_req,
    input  logic [NSRC-1:0] irq_src,
    input  logic            jammed,
    input  logic            iflag_prev,
    input  logic [2*DW-1:0] pc_in,
    input  logic [DW-1:0]   sp_in,
    input  logic [DW-1:0]   status_in,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] mem_addr,
    output logic            mem_wr,
    output logic            mem_rd,
    output logic [DW-1:0]   mem_wdata,
    output logic            busy,
    output logic            load,
    output logic [2*DW-1:0] pc_out,
    output logic [DW-1:0]   sp_out,
    output logic [DW-1:0]   status_out,
    output logic            jam_clr
);
    src_t pick;
    logic rst_pend, nmi_pend, start, drop_nmi, idle_bnd;

    // Start only at an idle boundary with something chosen.
    assign idle_bnd = boundary && !busy;
    assign start    = idle_bnd && (pick != SRC_NONE);
    assign drop_nmi = idle_bnd && jammed && !rst_pend;

    irq_seq_pend u_pend (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
        .start(start), .pick(pick), .drop_nmi(drop_nmi), .boundary(boundary),
        .rst_pend(rst_pend), .nmi_pend(nmi_pend)
    );

    irq_seq_arb #(.NSRC(NSRC)) u_arb (
        .irq_src(irq_src), .nmi_pend(nmi_pend), .rst_pend(rst_pend),
        .jammed(jammed), .iflag_prev(iflag_prev), .pick(pick)
    );

    irq_seq_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .kind_in(pick),
        .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .busy(busy), .load(load), .pc_out(pc_out), .sp_out(sp_out),
        .status_out(status_out), .jam_clr(jam_clr)
    );

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        start && pick == SRC_IRQ |-> !iflag_prev); // R1
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start && nmi_pend && !rst_pend |-> pick == SRC_NMI); // R2
    AST_JAM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        start && jammed |-> pick == SRC_RESET); // R3
    AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start && rst_pend |-> pick == SRC_RESET); // R9
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> busy); // R9
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary = 1'b0, rst_req = 1'b0, nmi_req = 1'b0;
    logic [3:0]  irq_src = '0;
    logic        jammed = 1'b0, iflag_prev = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0, status_in = '0;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] mem_addr, pc_out;
    logic        mem_wr, mem_rd, busy, load, jam_clr;
    logic [7:0]  mem_wdata, sp_out, status_out;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .rst_req(rst_req),
        .nmi_req(nmi_req), .irq_src(irq_src), .jammed(jammed), .iflag_prev(iflag_prev),
        .pc_in(pc_in), .sp_in(sp_in), .status_in(status_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .busy(busy), .load(load), .pc_out(pc_out), .sp_out(sp_out),
        .status_out(status_out), .jam_clr(jam_clr)
    );

    always #4 clk = ~clk;

    typedef struct {
        int    cyc;
        int    ev;      // 0 write, 1 read, 2 load
        logic [31:0] val;
        logic  jc;
        string req;
    } exp_t;

    exp_t expq[$];
    int   cyc = 0, checks = 0, errors = 0, activity = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Vector memory with one-cycle read latency.
    function automatic logic [7:0] vbyte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'hCD;
            16'hFFFF: return 8'hAB;
            default:  return 8'hEE;
        endcase
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= vbyte(mem_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor: every strobe must match the queue head, in its due cycle.
    always @(negedge clk) begin : mon
        int          oev;
        logic [31:0] oval;
        exp_t        e;
        if (rst_n && (mem_wr || mem_rd || load)) begin
            activity++;
            oev  = mem_wr ? 0 : (mem_rd ? 1 : 2);
            oval = mem_wr ? {8'h0, mem_addr, mem_wdata} :
                   mem_rd ? {mem_addr, 16'h0} : {pc_out, sp_out, status_out};
            if (expq.size() == 0) begin
                check(1'b0, "R9 unexpected event", oval, 32'h0);
            end else begin
                e = expq.pop_front();
                check(e.cyc == cyc && e.ev == oev, {e.req, " timing/kind"}, cyc, e.cyc);
                check(oval == e.val, e.req, oval, e.val);
                if (oev == 2) check(jam_clr == e.jc, {e.req, " jam_clr"}, {31'h0, jam_clr}, {31'h0, e.jc});
            end
        end
    end

    function automatic exp_t mk(input int c, input int ev, input logic [31:0] v, input logic jc, input string r);
        exp_t e;
        e.cyc = c; e.ev = ev; e.val = v; e.jc = jc; e.req = r;
        return e;
    endfunction

    // Driver: raise a boundary and queue what must follow. kind 0 reset, 1 NMI, 2 IRQ.
    task automatic fire(input int kind, input logic [15:0] pc, input logic [7:0] sp,
                        input logic [7:0] st, input string req);
        int n;
        logic [15:0] vec, vaddr;
        logic [7:0]  pst;
        @(negedge clk);
        pc_in = pc; sp_in = sp; status_in = st; boundary = 1'b1;
        n = cyc;
        if (kind == 0) begin
            expq.push_back(mk(n + 1, 1, {16'hFFFC, 16'h0}, 1'b0, {req, " R8 vec lo"}));
            expq.push_back(mk(n + 2, 1, {16'hFFFD, 16'h0}, 1'b0, {req, " R8 vec hi"}));
            expq.push_back(mk(n + 4, 2, {16'h8000, sp, 8'h04}, 1'b1, {req, " R8 load"}));
        end else begin
            vaddr = (kind == 1) ? 16'hFFFA : 16'hFFFE;
            vec   = (kind == 1) ? 16'h1234 : 16'hABCD;
            pst   = (st & 8'hEF) | 8'h20;
            expq.push_back(mk(n + 1, 0, {8'h0, 8'h01, sp, pc[15:8]}, 1'b0, {req, " R4 push PCH"}));
            expq.push_back(mk(n + 2, 0, {8'h0, 8'h01, sp - 8'd1, pc[7:0]}, 1'b0, {req, " R4 push PCL"}));
            expq.push_back(mk(n + 3, 0, {8'h0, 8'h01, sp - 8'd2, pst}, 1'b0, {req, " R4 push P"}));
            expq.push_back(mk(n + 4, 1, {vaddr, 16'h0}, 1'b0, {req, " R5 vec lo"}));
            expq.push_back(mk(n + 5, 1, {vaddr + 16'd1, 16'h0}, 1'b0, {req, " R5 vec hi"}));
            expq.push_back(mk(n + 7, 2, {vec, sp - 8'd3, (kind == 2) ? (st | 8'h04) : st}, 1'b0,
                              {req, " R6 R7 load"}));
        end
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (10) @(negedge clk);
        check(expq.size() == 0 && !busy, {req, " sequence complete"}, expq.size(), 0);
    endtask

    // A boundary that must cause nothing at all.
    task automatic quiet(input string req);
        int a0;
        @(negedge clk);
        a0 = activity; boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
        repeat (10) @(negedge clk);
        check(activity == a0, req, activity, a0);
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_req = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst_req = 1'b1;
        @(negedge clk); rst_req = 1'b0;
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: idle outputs during and after reset
        check(!busy && !mem_wr && !mem_rd && !load && !jam_clr, "R10 in reset",
              {27'h0, busy, mem_wr, mem_rd, load, jam_clr}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !mem_wr && !mem_rd && !load && !jam_clr, "R10 after reset",
              {27'h0, busy, mem_wr, mem_rd, load, jam_clr}, 32'h0);

        // R8: reset entry while halted
        jammed = 1'b1;
        pulse_rst();
        fire(0, 16'h4444, 8'h55, 8'hFF, "R8 reset jammed");
        drain("R8");
        jammed = 1'b0;

        // R1 R4 R5 R6 R7: basic maskable entry, break bit cleared in push
        irq_src = 4'b0100; iflag_prev = 1'b0;
        fire(2, 16'h1357, 8'hFD, 8'h91, "R1 irq");
        drain("R1");

        // R1: masked and absent requests
        iflag_prev = 1'b1;
        quiet("R1 masked irq ignored");
        irq_src = 4'b0000; iflag_prev = 1'b0;
        quiet("R1 no source bits");

        // R2: NMI beats IRQ even with the flag set; IRQ level kept
        irq_src = 4'b1000; iflag_prev = 1'b1;
        pulse_nmi();
        fire(1, 16'h2468, 8'h80, 8'h30, "R2 nmi over irq");
        drain("R2 nmi");
        iflag_prev = 1'b0;
        fire(2, 16'h2468, 8'h7D, 8'h30, "R2 irq held");
        drain("R2 irq");
        irq_src = 4'b0000;
        quiet("R2 nmi cleared after entry");

        // R3: halted core ignores NMI and IRQ, pending NMI is dropped
        jammed = 1'b1; irq_src = 4'b0001;
        pulse_nmi();
        quiet("R3 jammed ignores requests");
        jammed = 1'b0; irq_src = 4'b0000;
        quiet("R3 dropped nmi stays dropped");

        // R4: stack pointer wraps within the page
        irq_src = 4'b0010;
        fire(2, 16'hBEEF, 8'h01, 8'h00, "R4 wrap");
        drain("R4 wrap");

        // R9: requests and boundaries during a sequence wait
        fire(2, 16'h0F0F, 8'hF0, 8'h01, "R9 busy irq");
        nmi_req = 1'b1; boundary = 1'b1;
        @(negedge clk); nmi_req = 1'b0;
        @(negedge clk); boundary = 1'b0;
        drain("R9 busy irq");
        irq_src = 4'b0000;
        fire(1, 16'h0F0F, 8'hED, 8'h05, "R9 held nmi");
        drain("R9 held nmi");

        // R9: reset first, then held NMI
        irq_src = 4'b0001;
        pulse_nmi();
        pulse_rst();
        fire(0, 16'h1111, 8'h40, 8'h00, "R9 reset priority");
        drain("R9 reset");
        fire(1, 16'h2222, 8'h40, 8'h04, "R9 nmi after reset");
        drain("R9 nmi");
        irq_src = 4'b0000;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule